// File: doc/BRIEF.md
# RDMA Injection Packetizer with Inline CRC-32

This block turns queued remote-write transfer requests into network packets. Each request names a destination peer, a local source address, a remote destination address, a byte length and a tag. The block holds incoming requests in a small queue and serves them strictly first-come first-served. It cuts each transfer into fragments of at most 256 bytes. Each fragment becomes one packet. The packet has two header words, then the payload words read from local memory over a simple one-cycle-latency read port, then one trailing word that holds a CRC-32. The CRC is accumulated while the packet streams out.

Packets are written into an internal transmit FIFO, which the network side drains with a valid/ready handshake. Before the first header word of a packet is written, the block waits until the FIFO has room for the whole packet. Words of different packets therefore never mix. After the final fragment of a request has been queued, a one-cycle completion strobe reports that request's tag.

Top module: `inj_packetizer`

## Requirements
- R1: While and right after synchronous reset, `tx_valid`, `rd_req` and `done_valid` are 0 and `desc_ready` is 1.
- R2: A request is taken on a clock edge where `desc_valid` and `desc_ready` are both 1. Requests are served in the order taken: their packets and completion strobes come out in that order.
- R3: A request of L bytes produces ceil(L/256) packets, or one packet when L is 0. Every packet except the last carries 256 bytes and the last carries the remainder. A zero-length request gives a packet with no payload words.
- R4: Payload word i of a fragment is read from byte address (fragment source + 8*i). The read data is taken one cycle after `rd_req`, and consecutive reads step `rd_addr` by 8.
- R5: Header word 0 holds the peer in bits 63:56, the tag in bits 55:48, the fragment byte count in bits 15:0, and zeros elsewhere. Header word 1 holds the fragment's remote address, zero-extended.
- R6: From one fragment to the next, both the local source address and the remote address advance by the previous fragment's byte count.
- R7: In a last payload word that is only partly used, bytes at or above the byte count modulo 8 are sent as zero. Byte k of a word is bits 8k+7:8k.
- R8: The final word of every packet carries, in bits 31:0, the reflected CRC-32 (polynomial 0x04C11DB7, initial value 0xFFFFFFFF, final XOR 0xFFFFFFFF), with bits 63:32 zero. The CRC covers the header and payload words, each fed byte 0 first. `tx_last` is 1 on that word and on no other.
- R9: No word of a packet is written until the transmit FIFO has room for all of the packet's words, so packets are never interleaved and the FIFO never overflows.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R11: `done_valid` is a single-cycle pulse carrying the request's tag in `done_tag`. It occurs once per request, in the cycle after the last fragment's CRC word enters the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Request present |
| desc_ready | output | 1 | Request queue has space |
| desc_peer | input | 8 | Destination peer |
| desc_tag | input | 8 | Request tag |
| desc_src | input | 48 | Local source byte address (word aligned) |
| desc_dst | input | 48 | Remote destination byte address |
| desc_len | input | 16 | Transfer length in bytes |
| rd_req | output | 1 | Memory read strobe |
| rd_addr | output | 48 | Memory read byte address |
| rd_data | input | 64 | Read data, valid the cycle after `rd_req` |
| tx_valid | output | 1 | Transmit word present |
| tx_ready | input | 1 | Network side takes the word |
| tx_data | output | 64 | Transmit word |
| tx_last | output | 1 | Word is the packet's CRC word |
| done_valid | output | 1 | Request completion strobe |
| done_tag | output | 8 | Tag of the completed request |

## Verification
The properties assume that memory answers every read exactly one cycle after `rd_req`, with no stall path, and that source addresses are multiples of 8. The bench meets both assumptions. Its memory model registers a word computed from the address on every strobe, and every request in its table and its directed tests uses an aligned source. The network side is left free: the bench holds `tx_ready` low for long stretches and also toggles it in a fixed pattern. This exercises both the whole-packet space reservation and the output hold.

// File: rtl/inj_pkg.sv
package inj_pkg;

    localparam int WORD_W         = 64;
    localparam int ADDR_W         = 48;
    localparam int PEER_W         = 8;
    localparam int TAG_W          = 8;
    localparam int LEN_W          = 16;
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int BYTE_SH        = $clog2(BYTES_PER_WORD);
    localparam int HDR_WORDS      = 2;
    localparam int CRC_W          = 32;

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [PEER_W-1:0] peer;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPACE,
        ST_HDR0,
        ST_HDR1,
        ST_PAY,
        ST_TAIL
    } eng_state_t;

    // Advance a reflected CRC over one word, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_word(input logic [CRC_W-1:0] c,
                                                       input logic [WORD_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < WORD_W; i++) begin
            if (r[0] ^ d[i])
                r = (r >> 1) ^ CRC_POLY_REFL;
            else
                r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] make_hdr_route(input logic [PEER_W-1:0] peer,
                                                         input logic [TAG_W-1:0]  tag,
                                                         input logic [LEN_W-1:0]  flen);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1 -: PEER_W]          = peer;
        w[WORD_W-PEER_W-1 -: TAG_W]    = tag;
        w[LEN_W-1:0]                   = flen;
        return w;
    endfunction

endpackage

// File: rtl/inj_sync_fifo.sv
module inj_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          full, empty, do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= bump(wp_q);
            if (do_rd) rp_q <= bump(rp_q);
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/inj_engine.sv
module inj_engine
    import inj_pkg::*;
#(
    parameter int MAX_BYTES = 256,
    parameter int TX_DEPTH  = 64,
    parameter int CNT_W     = $clog2(TX_DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dq_empty,
    input  desc_t               dq_data,
    output logic                dq_pop,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [WORD_W-1:0]   rd_data,
    input  logic [CNT_W-1:0]    tx_count,
    output logic                wr_en,
    output logic [WORD_W-1:0]   wr_data,
    output logic                wr_last,
    output logic                done_valid,
    output logic [TAG_W-1:0]    done_tag
);
    localparam int MAX_WORDS = MAX_BYTES / BYTES_PER_WORD;
    localparam int WC_W      = $clog2(MAX_WORDS + 1);
    localparam int OVERHEAD  = HDR_WORDS + 1;
    localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(MAX_BYTES);
    localparam logic [LEN_W-1:0] WORD_RND = LEN_W'(BYTES_PER_WORD - 1);

    eng_state_t          state_q;
    desc_t               cur_q;
    logic [LEN_W-1:0]    flen_q;
    logic [WC_W-1:0]     fwords_q;
    logic [WC_W-1:0]     rd_cnt_q, wr_cnt_q;
    logic                rd_pend_q;
    logic [CRC_W-1:0]    crc_q;
    logic                done_q;
    logic [TAG_W-1:0]    done_tag_q;

    logic [LEN_W-1:0]    flen_c;
    logic [WC_W-1:0]     fwords_c;
    logic                fits_c;
    logic                last_frag_c;
    logic                last_word_c;
    logic [BYTE_SH-1:0]  tail_bytes;
    logic [WORD_W-1:0]   pay_word;

    // Fragment sizing from what is left of the current request.
    assign flen_c      = (cur_q.len > MAX_LEN) ? MAX_LEN : cur_q.len;
    assign fwords_c    = WC_W'((flen_c + WORD_RND) >> BYTE_SH);
    assign fits_c      = (int'(tx_count) + int'(fwords_c) + OVERHEAD) <= TX_DEPTH;
    assign last_frag_c = (cur_q.len <= MAX_LEN);
    assign last_word_c = (wr_cnt_q == fwords_q - WC_W'(1));
    assign tail_bytes  = flen_q[BYTE_SH-1:0];

    // Zero the unused top bytes of a partly used final word.
    always_comb begin
        for (int b = 0; b < BYTES_PER_WORD; b++) begin
            if (last_word_c && (tail_bytes != '0) && (b >= int'(tail_bytes)))
                pay_word[8*b +: 8] = 8'h00;
            else
                pay_word[8*b +: 8] = rd_data[8*b +: 8];
        end
    end

    always_comb begin
        dq_pop  = (state_q == ST_IDLE) && !dq_empty;
        rd_req  = (state_q == ST_PAY) && (rd_cnt_q != fwords_q);
        rd_addr = cur_q.src + (ADDR_W'(rd_cnt_q) << BYTE_SH);
        wr_en   = 1'b0;
        wr_last = 1'b0;
        wr_data = '0;
        case (state_q)
            ST_HDR0: begin
                wr_en   = 1'b1;
                wr_data = make_hdr_route(cur_q.peer, cur_q.tag, flen_q);
            end
            ST_HDR1: begin
                wr_en   = 1'b1;
                wr_data = WORD_W'(cur_q.dst);
            end
            ST_PAY: begin
                wr_en   = rd_pend_q;
                wr_data = pay_word;
            end
            ST_TAIL: begin
                wr_en   = 1'b1;
                wr_last = 1'b1;
                wr_data = {{(WORD_W-CRC_W){1'b0}}, ~crc_q};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cur_q      <= '0;
            flen_q     <= '0;
            fwords_q   <= '0;
            rd_cnt_q   <= '0;
            wr_cnt_q   <= '0;
            rd_pend_q  <= 1'b0;
            crc_q      <= CRC_SEED;
            done_q     <= 1'b0;
            done_tag_q <= '0;
        end else begin
            done_q    <= 1'b0;
            rd_pend_q <= rd_req;
            if (wr_en && !wr_last)
                crc_q <= crc_step_word(crc_q, wr_data);
            if (rd_req)
                rd_cnt_q <= rd_cnt_q + 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (!dq_empty) begin
                        cur_q   <= dq_data;
                        state_q <= ST_SPACE;
                    end
                end
                ST_SPACE: begin
                    flen_q   <= flen_c;
                    fwords_q <= fwords_c;
                    crc_q    <= CRC_SEED;
                    if (fits_c)
                        state_q <= ST_HDR0;
                end
                ST_HDR0: state_q <= ST_HDR1;
                ST_HDR1: begin
                    rd_cnt_q <= '0;
                    wr_cnt_q <= '0;
                    state_q  <= (fwords_q == '0) ? ST_TAIL : ST_PAY;
                end
                ST_PAY: begin
                    if (rd_pend_q) begin
                        wr_cnt_q <= wr_cnt_q + 1'b1;
                        if (last_word_c)
                            state_q <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    cur_q.src <= cur_q.src + ADDR_W'(flen_q);
                    cur_q.dst <= cur_q.dst + ADDR_W'(flen_q);
                    cur_q.len <= cur_q.len - flen_q;
                    if (last_frag_c) begin
                        done_q     <= 1'b1;
                        done_tag_q <= cur_q.tag;
                        state_q    <= ST_IDLE;
                    end else begin
                        state_q <= ST_SPACE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_valid = done_q;
    assign done_tag   = done_tag_q;

endmodule

// File: rtl/inj_packetizer.sv
module inj_packetizer
    import inj_pkg::*;
#(
    parameter int MAX_BYTES  = 256,
    parameter int DESC_DEPTH = 4,
    parameter int TX_DEPTH   = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                desc_valid,
    output logic                desc_ready,
    input  logic [PEER_W-1:0]   desc_peer,
    input  logic [TAG_W-1:0]    desc_tag,
    input  logic [ADDR_W-1:0]   desc_src,
    input  logic [ADDR_W-1:0]   desc_dst,
    input  logic [LEN_W-1:0]    desc_len,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [WORD_W-1:0]   rd_data,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic [WORD_W-1:0]   tx_data,
    output logic                tx_last,
    output logic                done_valid,
    output logic [TAG_W-1:0]    done_tag
);
    localparam int DQ_CW  = $clog2(DESC_DEPTH) + 1;
    localparam int TXQ_CW = $clog2(TX_DEPTH) + 1;
    localparam int TXQ_W  = WORD_W + 1;

    desc_t              dq_in, dq_out;
    logic [DQ_CW-1:0]   dq_count;
    logic               dq_empty, dq_pop;

    logic               txq_wr, txq_wlast, txq_full, txq_rd;
    logic [WORD_W-1:0]  txq_wdata;
    logic [TXQ_W-1:0]   txq_rdata;
    logic [TXQ_CW-1:0]  txq_count;

    assign dq_in      = '{peer: desc_peer, tag: desc_tag, src: desc_src,
                          dst: desc_dst, len: desc_len};
    assign desc_ready = (dq_count != DQ_CW'(DESC_DEPTH));
    assign dq_empty   = (dq_count == '0);

    inj_sync_fifo #(
        .W     ($bits(desc_t)),
        .DEPTH (DESC_DEPTH),
        .CW    (DQ_CW)
    ) u_desc_q (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (desc_valid),
        .wr_data (dq_in),
        .rd_en   (dq_pop),
        .rd_data (dq_out),
        .count   (dq_count)
    );

    inj_engine #(
        .MAX_BYTES (MAX_BYTES),
        .TX_DEPTH  (TX_DEPTH),
        .CNT_W     (TXQ_CW)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .dq_empty   (dq_empty),
        .dq_data    (dq_out),
        .dq_pop     (dq_pop),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .tx_count   (txq_count),
        .wr_en      (txq_wr),
        .wr_data    (txq_wdata),
        .wr_last    (txq_wlast),
        .done_valid (done_valid),
        .done_tag   (done_tag)
    );

    assign txq_full = (txq_count == TXQ_CW'(TX_DEPTH));
    assign tx_valid = (txq_count != '0);
    assign txq_rd   = tx_valid && tx_ready;

    inj_sync_fifo #(
        .W     (TXQ_W),
        .DEPTH (TX_DEPTH),
        .CW    (TXQ_CW)
    ) u_tx_q (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (txq_wr),
        .wr_data ({txq_wlast, txq_wdata}),
        .rd_en   (txq_rd),
        .rd_data (txq_rdata),
        .count   (txq_count)
    );

    assign tx_last = txq_rdata[WORD_W];
    assign tx_data = txq_rdata[WORD_W-1:0];

endmodule

// File: rtl/inj_packetizer_chk.sv
module inj_packetizer_chk
    import inj_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [WORD_W-1:0] tx_data,
    input logic              tx_last,
    input logic              done_valid,
    input logic              txq_wr,
    input logic              txq_wlast,
    input logic              txq_full
);
    // R9: a packet is only started with room for all of it, so no write hits a full FIFO.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        txq_wr |-> !txq_full);

    // R4: back-to-back payload reads walk memory in 8-byte steps.
    a_r4_read_stride: assert property (@(posedge clk) disable iff (rst)
        (rd_req && $past(rd_req)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(BYTES_PER_WORD)));

    // R10: a word refused by the network side stays put.
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R11: completion lasts one cycle.
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    // R11: completion follows the queuing of a CRC word.
    a_r11_done_after_crc: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(txq_wr && txq_wlast));

    // R1: nothing is offered while reset is applied.
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tx_valid && !done_valid && !rd_req));

endmodule

bind inj_packetizer inj_packetizer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .done_valid (done_valid),
    .txq_wr     (txq_wr),
    .txq_wlast  (txq_wlast),
    .txq_full   (txq_full)
);

// File: tb/inj_packetizer_test.sv
`timescale 1ns/1ps
module inj_packetizer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [7:0]  desc_peer = '0;
    logic [7:0]  desc_tag = '0;
    logic [47:0] desc_src = '0;
    logic [47:0] desc_dst = '0;
    logic [15:0] desc_len = '0;
    logic        rd_req;
    logic [47:0] rd_addr;
    logic [63:0] rd_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [63:0] tx_data;
    logic        tx_last;
    logic        done_valid;
    logic [7:0]  done_tag;

    always #2 clk = ~clk;

    inj_packetizer uut (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_peer(desc_peer), .desc_tag(desc_tag),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .done_valid(done_valid), .done_tag(done_tag)
    );

    function automatic logic [63:0] mem_word(input logic [47:0] a);
        return {a[31:0] ^ 32'h5A5A_0000, ~a[31:0]};
    endfunction

    // Memory model: one-cycle read latency.
    always @(posedge clk) if (rd_req) rd_data <= mem_word(rd_addr);

    int checks = 0;
    int fails  = 0;
    logic [64:0] cap [2048];
    int cap_n = 0;
    int rp = 0;
    logic [7:0] dtags [64];
    int done_n = 0;
    int rdreq_n = 0;
    logic [31:0] crc_acc;

    always @(negedge clk) begin
        if (tx_valid && tx_ready && cap_n < 2048) begin
            cap[cap_n] = {tx_last, tx_data};
            cap_n++;
        end
        if (done_valid && done_n < 64) begin
            dtags[done_n] = done_tag;
            done_n++;
        end
        if (rd_req) rdreq_n++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        return r;
    endfunction

    task automatic take(input logic [63:0] exp, input bit exp_last, input string req);
        logic [64:0] w;
        if (rp >= cap_n) begin
            chk(1'b0, req, "missing word", 64'h0, exp);
            return;
        end
        w = cap[rp];
        rp++;
        chk(w[63:0] == exp && w[64] == exp_last, req, exp_last ? "crc word" : "word",
            {w[64], w[62:0]}, {exp_last, exp[62:0]});
        if (!exp_last)
            for (int b = 0; b < 8; b++) crc_acc = crc_byte(crc_acc, exp[8*b +: 8]);
    endtask

    task automatic verify(input logic [7:0] peer, input logic [7:0] tag, input logic [15:0] len,
                          input int nfrag, input logic [47:0] src, input logic [47:0] dst);
        int rem;
        logic [47:0] s;
        logic [47:0] d;
        rem = int'(len);
        s = src;
        d = dst;
        for (int f = 0; f < nfrag; f++) begin
            int fl;
            int nw;
            logic [63:0] e;
            fl = (rem > 256) ? 256 : rem;
            nw = (fl + 7) / 8;
            crc_acc = 32'hFFFF_FFFF;
            take({peer, tag, 32'h0, 16'(fl)}, 1'b0, "R5 header0");
            take({16'h0, d}, 1'b0, "R6 header1");
            for (int i = 0; i < nw; i++) begin
                e = mem_word(s + 48'(8 * i));
                if (i == nw - 1 && (fl % 8) != 0)
                    for (int b = 0; b < 8; b++) if (b >= fl % 8) e[8*b +: 8] = 8'h00;
                take(e, 1'b0, (i == nw - 1) ? "R7 R4 payload" : "R4 payload");
            end
            take({32'h0, ~crc_acc}, 1'b1, "R8");
            s = s + 48'(fl);
            d = d + 48'(fl);
            rem = rem - fl;
        end
        chk(rem == 0, "R3", "fragments cover length", 64'(rem), 64'h0);
    endtask

    task automatic push(input logic [7:0] peer, input logic [7:0] tag, input logic [15:0] len,
                        input logic [47:0] src, input logic [47:0] dst);
        bit acc;
        @(posedge clk); #1;
        desc_valid = 1'b1;
        desc_peer = peer; desc_tag = tag; desc_len = len;
        desc_src = src; desc_dst = dst;
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            acc = desc_ready;
            @(posedge clk); #1;
        end
        desc_valid = 1'b0;
    endtask

    task automatic settle(input int n_done);
        while (done_n < n_done) @(negedge clk);
        repeat (3) @(negedge clk);
        while (tx_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // peer, tag, len, expected fragment count, src, dst
    localparam int NV = 7;
    localparam logic [135:0] VEC [NV] = '{
        {8'h03, 8'h11, 16'd64,   8'd1, 48'h0000_0000_1000, 48'h0000_8000_0000},
        {8'h07, 8'h12, 16'd13,   8'd1, 48'h0000_0000_2000, 48'h0000_0000_0040},
        {8'h1F, 8'h13, 16'd600,  8'd3, 48'h0000_0000_3000, 48'h0009_0000_0000},
        {8'h80, 8'h14, 16'd0,    8'd1, 48'h0000_0000_4000, 48'h0000_0000_0100},
        {8'hFE, 8'h15, 16'd1000, 8'd4, 48'h0000_0000_5008, 48'h0000_7777_0000},
        {8'h2A, 8'h16, 16'd256,  8'd1, 48'h0000_0000_6000, 48'h0000_0000_0200},
        {8'h55, 8'h17, 16'd257,  8'd2, 48'h0000_0000_7000, 48'h0000_0000_0300}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int base;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state, sampled while reset is applied
        chk(tx_valid == 1'b0, "R1", "tx_valid in reset", 64'(tx_valid), 64'h0);
        chk(rd_req == 1'b0, "R1", "rd_req in reset", 64'(rd_req), 64'h0);
        chk(done_valid == 1'b0, "R1", "done_valid in reset", 64'(done_valid), 64'h0);
        chk(desc_ready == 1'b1, "R1", "desc_ready in reset", 64'(desc_ready), 64'h1);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(tx_valid == 1'b0 && done_valid == 1'b0, "R1", "idle after reset",
            {tx_valid, done_valid}, 64'h0);

        // Table walk: one request at a time.
        for (int v = 0; v < NV; v++) begin
            base = done_n;
            push(VEC[v][135:128], VEC[v][127:120], VEC[v][119:104],
                 VEC[v][95:48], VEC[v][47:0]);
            settle(base + 1);
            verify(VEC[v][135:128], VEC[v][127:120], VEC[v][119:104],
                   int'(VEC[v][103:96]), VEC[v][95:48], VEC[v][47:0]);
            chk(done_n == base + 1, "R11", "one completion", 64'(done_n - base), 64'h1);
            chk(dtags[base] == VEC[v][127:120], "R11", "completion tag",
                64'(dtags[base]), 64'(VEC[v][127:120]));
        end

        // R2 ordering: three requests back to back.
        base = done_n;
        push(8'h21, 8'h31, 16'd40,  48'h8000, 48'hA000);
        push(8'h22, 8'h32, 16'd300, 48'h9000, 48'hB000);
        push(8'h23, 8'h33, 16'd5,   48'hC000, 48'hD000);
        settle(base + 3);
        verify(8'h21, 8'h31, 16'd40,  1, 48'h8000, 48'hA000);
        verify(8'h22, 8'h32, 16'd300, 2, 48'h9000, 48'hB000);
        verify(8'h23, 8'h33, 16'd5,   1, 48'hC000, 48'hD000);
        chk(dtags[base] == 8'h31 && dtags[base+1] == 8'h32 && dtags[base+2] == 8'h33,
            "R2", "completion order", {40'h0, dtags[base], dtags[base+1], dtags[base+2]},
            64'h31_3233);

        // R9 stall: output blocked, second packet must wait for room.
        base = done_n;
        @(posedge clk); #1;
        tx_ready = 1'b0;
        push(8'h41, 8'h51, 16'd256, 48'hE000, 48'h1_0000);
        push(8'h42, 8'h52, 16'd256, 48'hF000, 48'h2_0000);
        repeat (150) @(negedge clk);
        rdreq_n = 0;
        repeat (60) @(negedge clk);
        chk(rdreq_n == 0, "R9", "no reads while waiting for room", 64'(rdreq_n), 64'h0);
        chk(done_n == base + 1, "R9", "only first packet queued", 64'(done_n - base), 64'h1);
        chk(tx_valid == 1'b1, "R10", "word held while blocked", 64'(tx_valid), 64'h1);
        chk(tx_data == {8'h41, 8'h51, 32'h0, 16'd256}, "R10", "held header",
            tx_data, {8'h41, 8'h51, 32'h0, 16'd256});
        @(posedge clk); #1;
        tx_ready = 1'b1;
        settle(base + 2);
        verify(8'h41, 8'h51, 16'd256, 1, 48'hE000, 48'h1_0000);
        verify(8'h42, 8'h52, 16'd256, 1, 48'hF000, 48'h2_0000);

        // R10 with a toggling consumer across a multi-fragment request.
        base = done_n;
        fork
            push(8'h61, 8'h71, 16'd700, 48'h1_8000, 48'h3_0000);
            begin
                for (int t = 0; t < 400; t++) begin
                    @(posedge clk); #1;
                    tx_ready = (t % 3) != 0;
                end
                tx_ready = 1'b1;
            end
        join
        settle(base + 1);
        verify(8'h61, 8'h71, 16'd700, 3, 48'h1_8000, 48'h3_0000);
        chk(rp == cap_n, "R9", "no stray words", 64'(cap_n - rp), 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule